// File: doc/BRIEF.md
# Serial channel FIFO control with DMA request logic

This block keeps the character buffering for one serial channel: a transmit queue filled by host writes and drained by the serial side, and a receive queue filled by the serial side and drained by host reads. An 8-bit control register turns the queues on or off, empties either queue on command, sets the receive trigger level and picks one of two rules for the DMA request outputs. The serial side is reduced to strobes (take one transmit character, deliver one received character) and a receive time-out pulse.

With the queues turned off, each direction behaves as a single holding register. With them on, each holds up to `DEPTH` characters. Two active-low request outputs tell a DMA controller when to move transmit and receive data, and a level-sensitive flag reports that the receive queue has reached its trigger level.

Top module: `uart_fifo_ctl`

## Requirements
- R1: A control write with bit 0 = 0 clears the enable and leaves bits 7:1 as they were; with bit 0 = 1 it also loads bit 3 (DMA mode) and bits 7:6 (trigger). Readback is {trigger[1:0], 0, 0, mode, 0, 0, enable}.
- R2: With the enable at 0 each direction holds one character; a second one is dropped. Any write that changes the enable bit empties both queues.
- R3: In a control write with bit 0 = 1, bit 1 empties the receive queue and bit 2 empties the transmit queue, each leaving the other queue untouched and winning over a push in the same cycle; both bits read back as 0.
- R4: With the enable at 1 each queue holds `DEPTH` (16) characters and delivers them in arrival order.
- R5: A host write to a full transmit queue and a serial push into a full receive queue are dropped; the host write case sets the sticky `tx_ovf` flag.
- R6: A host read of an empty receive queue returns 0, changes nothing and sets the sticky `rx_udf` flag.
- R7: Trigger codes 00, 01, 10, 11 mean 1, 4, 8 and 14 characters; `rx_irq` is 1 while the enable is 1 and the receive count is at or above that level.
- R8: In mode 0 or with the enable at 0, `txreq_n` is 0 when the transmit queue is empty and 1 otherwise.
- R9: In mode 0 or with the enable at 0, `rxreq_n` is 0 while the receive queue holds a character and 1 when it is empty.
- R10: In mode 1 with the enable at 1, `txreq_n` is 1 only when the transmit queue holds `DEPTH` characters.
- R11: In mode 1 with the enable at 1, `rxreq_n` falls in the cycle the receive count reaches the trigger level or a time-out pulse arrives while data is held, and stays 0 until the receive queue is empty.
- R12: Synchronous active-low reset clears all registers: control readback 0, `txreq_n` 0, `rxreq_n` 1, `rx_irq`, `tx_ovf` and `rx_udf` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value |
| ctl_rdata | output | 8 | Control readback |
| host_wr | input | 1 | Host writes one transmit character |
| host_wdata | input | DW | Transmit character from host |
| host_rd | input | 1 | Host takes one received character |
| host_rdata | output | DW | Oldest received character, 0 when empty |
| tx_pop | input | 1 | Serial side takes one transmit character |
| tx_data | output | DW | Oldest transmit character |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Serial side delivers one character |
| rx_data | input | DW | Received character |
| rx_timeout | input | 1 | Receive time-out pulse |
| txreq_n | output | 1 | Transmit DMA request, active low |
| rxreq_n | output | 1 | Receive DMA request, active low |
| rx_irq | output | 1 | Receive trigger level reached |
| tx_ovf | output | 1 | Sticky: write to full transmit queue |
| rx_udf | output | 1 | Sticky: read of empty receive queue |

## Verification
The bench builds the block with its defaults, `DEPTH` = 16, 8-bit characters and trigger levels 1, 4, 8 and 14. At that size every receive count from 0 to 16 can be walked for each of the four trigger codes in both DMA modes, so each step of `rx_irq` and `rxreq_n` is compared against an arithmetic expectation, and a full transmit queue is filled and drained in both modes to check the request edge and the ordering. Flush, enable toggling, time-out and the one-deep holding behaviour are driven on top of that sweep.

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int LVL0  = 1,
  parameter int LVL1  = 4,
  parameter int LVL2  = 8,
  parameter int LVL3  = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [DW-1:0] host_rdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_data,
  output logic          tx_avail,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_timeout,
  output logic          txreq_n,
  output logic          rxreq_n,
  output logic          rx_irq,
  output logic          tx_ovf,
  output logic          rx_udf
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          fen, dma1, rx_hold;
  logic [1:0]    trig;
  logic [CW-1:0] tx_cnt, rx_cnt, tx_cnt_nx, rx_cnt_nx, cap, lvl;
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];

  function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap = fen ? CW'(DEPTH) : CW'(1);

  always_comb begin
    case (trig)
      2'd0:    lvl = CW'(LVL0);
      2'd1:    lvl = CW'(LVL1);
      2'd2:    lvl = CW'(LVL2);
      default: lvl = CW'(LVL3);
    endcase
  end

  wire cfg_ok  = ctl_we & ctl_wdata[0];
  wire fen_chg = ctl_we & (ctl_wdata[0] != fen);
  wire tx_clr  = fen_chg | (cfg_ok & ctl_wdata[2]);
  wire rx_clr  = fen_chg | (cfg_ok & ctl_wdata[1]);
  wire tx_in   = host_wr & (tx_cnt < cap);
  wire tx_out  = tx_pop & (tx_cnt != '0);
  wire rx_in   = rx_push & (rx_cnt < cap);
  wire rx_out  = host_rd & (rx_cnt != '0);

  assign tx_cnt_nx = tx_clr ? '0 : tx_cnt + CW'(tx_in) - CW'(tx_out);
  assign rx_cnt_nx = rx_clr ? '0 : rx_cnt + CW'(rx_in) - CW'(rx_out);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fen     <= 1'b0;
      dma1    <= 1'b0;
      trig    <= 2'd0;
      tx_cnt  <= '0;
      rx_cnt  <= '0;
      tx_wp   <= '0;
      tx_rp   <= '0;
      rx_wp   <= '0;
      rx_rp   <= '0;
      rx_hold <= 1'b0;
      tx_ovf  <= 1'b0;
      rx_udf  <= 1'b0;
    end else begin
      if (ctl_we) begin
        fen <= ctl_wdata[0];
        if (ctl_wdata[0]) begin
          dma1 <= ctl_wdata[3];
          trig <= ctl_wdata[7:6];
        end
      end
      if (tx_clr) begin
        tx_wp <= '0;
        tx_rp <= '0;
      end else begin
        if (tx_in)  tx_wp <= adv(tx_wp);
        if (tx_out) tx_rp <= adv(tx_rp);
      end
      if (rx_clr) begin
        rx_wp <= '0;
        rx_rp <= '0;
      end else begin
        if (rx_in)  rx_wp <= adv(rx_wp);
        if (rx_out) rx_rp <= adv(rx_rp);
      end
      tx_cnt  <= tx_cnt_nx;
      rx_cnt  <= rx_cnt_nx;
      rx_hold <= (rx_hold | (rx_cnt_nx >= lvl) | rx_timeout) & (rx_cnt_nx != '0);
      if (host_wr & ~tx_in)          tx_ovf <= 1'b1;
      if (host_rd & (rx_cnt == '0))  rx_udf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (tx_in & ~tx_clr) tx_mem[tx_wp] <= host_wdata;
    if (rx_in & ~rx_clr) rx_mem[rx_wp] <= rx_data;
  end

  wire m1 = fen & dma1;

  assign ctl_rdata  = {trig, 2'b00, dma1, 2'b00, fen};
  assign host_rdata = (rx_cnt != '0) ? rx_mem[rx_rp] : '0;
  assign tx_data    = tx_mem[tx_rp];
  assign tx_avail   = (tx_cnt != '0);
  assign txreq_n    = m1 ? (tx_cnt == CW'(DEPTH)) : (tx_cnt != '0);
  assign rxreq_n    = m1 ? ~rx_hold : (rx_cnt == '0);
  assign rx_irq     = fen & (rx_cnt >= lvl);
endmodule

// File: rtl/uart_fifo_ctl_chk.sv
module uart_fifo_ctl_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_we,
  input logic [7:0]    ctl_wdata,
  input logic [7:0]    ctl_rdata,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          fen,
  input logic          dma1,
  input logic          rxreq_n,
  input logic          rx_irq,
  input logic          tx_ovf,
  input logic          rx_udf
);
  a_r1_keep_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !ctl_wdata[0]) |=> (ctl_rdata[7:1] == $past(ctl_rdata[7:1])));

  a_r2_single_deep: assert property (@(posedge clk) disable iff (!rst_n)
    !fen |-> (tx_cnt <= 1 && rx_cnt <= 1));

  a_r3_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[0] && ctl_wdata[1]) |=> (rx_cnt == '0));

  a_r3_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[0] && ctl_wdata[2]) |=> (tx_cnt == '0));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= DEPTH) && (rx_cnt <= DEPTH));

  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovf |=> tx_ovf);

  a_r6_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_udf |=> rx_udf);

  a_r7_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (rx_cnt != '0));

  a_r11_release_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (fen && dma1 && $stable(fen) && $stable(dma1) && $rose(rxreq_n)) |-> (rx_cnt == '0));
endmodule

bind uart_fifo_ctl uart_fifo_ctl_chk #(.DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .fen(fen),
  .dma1(dma1), .rxreq_n(rxreq_n), .rx_irq(rx_irq), .tx_ovf(tx_ovf),
  .rx_udf(rx_udf)
);

// File: tb/uart_fifo_ctl_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_ctl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
  logic       tx_pop = 1'b0, rx_push = 1'b0, rx_timeout = 1'b0;
  logic [7:0] ctl_wdata = '0, host_wdata = '0, rx_data = '0;
  logic [7:0] ctl_rdata, host_rdata, tx_data;
  logic       tx_avail, txreq_n, rxreq_n, rx_irq, tx_ovf, rx_udf;
  int         nrun = 0, nfail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  uart_fifo_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata), .tx_pop(tx_pop),
    .tx_data(tx_data), .tx_avail(tx_avail), .rx_push(rx_push),
    .rx_data(rx_data), .rx_timeout(rx_timeout), .txreq_n(txreq_n),
    .rxreq_n(rxreq_n), .rx_irq(rx_irq), .tx_ovf(tx_ovf), .rx_udf(rx_udf)
  );

  task automatic chk(input string req, input int act, input int exp);
    nrun++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  endtask

  function automatic int lvl_of(input int t);
    case (t)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic ctl(input logic [7:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(posedge clk); #1 ctl_we = 1'b0;
  endtask
  task automatic hw(input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_wdata = d;
    @(posedge clk); #1 host_wr = 1'b0;
  endtask
  task automatic hr();
    @(negedge clk); host_rd = 1'b1;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask
  task automatic rp(input logic [7:0] d);
    @(negedge clk); rx_push = 1'b1; rx_data = d;
    @(posedge clk); #1 rx_push = 1'b0;
  endtask
  task automatic tp();
    @(negedge clk); tx_pop = 1'b1;
    @(posedge clk); #1 tx_pop = 1'b0;
  endtask
  task automatic tmo();
    @(negedge clk); rx_timeout = 1'b1;
    @(posedge clk); #1 rx_timeout = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R12 reset state
    chk("R12 ctl", ctl_rdata, 0);
    chk("R12 txreq_n", txreq_n, 0);
    chk("R12 rxreq_n", rxreq_n, 1);
    chk("R12 irq", rx_irq, 0);
    chk("R12 flags", {tx_ovf, rx_udf}, 0);

    // R2 one-deep holding with queues off, R8/R9 mode 0 rules
    hw(8'hA1);
    chk("R8 tx held", txreq_n, 1);
    hw(8'hB2);
    chk("R5 ovf", tx_ovf, 1);
    chk("R2 first kept", tx_data, 8'hA1);
    tp();
    chk("R2 second dropped", tx_avail, 0);
    chk("R8 tx empty", txreq_n, 0);
    rp(8'h11); rp(8'h22);
    chk("R9 rx data", rxreq_n, 0);
    chk("R2 rx first", host_rdata, 8'h11);
    hr();
    chk("R2 rx second dropped", rxreq_n, 1);
    chk("R6 empty read data", host_rdata, 0);
    chk("R6 udf clear", rx_udf, 0);
    hr();
    chk("R6 udf set", rx_udf, 1);
    chk("R6 still empty", rxreq_n, 1);

    // R1 control register write rules
    ctl(8'hC9);
    chk("R1 load", ctl_rdata, 8'hC9);
    ctl(8'hF6);
    chk("R1 bit0 clear keeps rest", ctl_rdata, 8'hC8);
    ctl(8'h37);
    chk("R1 R3 readback", ctl_rdata, 8'h01);

    // R4 R7 R9 R11 receive sweep, all trigger codes, both modes
    for (int md = 0; md < 2; md++) begin
      for (int tg = 0; tg < 4; tg++) begin
        ctl(8'((tg << 6) | (md << 3) | 1));
        for (int n = 1; n <= 17; n++) begin
          rp(8'(md * 64 + tg * 16 + n));
          if (n <= 16) begin
            chk("R7 irq", rx_irq, int'(n >= lvl_of(tg)));
            chk(md ? "R11 rx req" : "R9 rx req", rxreq_n,
                md ? int'(n < lvl_of(tg)) : 0);
          end
        end
        for (int k = 0; k < 16; k++) begin
          chk("R4 R5 rx order", host_rdata, (md * 64 + tg * 16 + k + 1) & 8'hFF);
          hr();
          chk(md ? "R11 held until empty" : "R9 rx req", rxreq_n, int'(k == 15));
          chk("R7 irq drain", rx_irq, int'(15 - k >= lvl_of(tg)));
        end
      end
      // R4 R10 R8 transmit fill and drain
      for (int n = 1; n <= 16; n++) begin
        hw(8'(md * 32 + n));
        chk(md ? "R10 tx req" : "R8 tx req", txreq_n, md ? int'(n == 16) : 1);
      end
      hw(8'hEE);
      for (int k = 0; k < 16; k++) begin
        chk("R4 R5 tx order", tx_data, md * 32 + k + 1);
        tp();
        chk(md ? "R10 tx req" : "R8 tx req", txreq_n, md ? 0 : int'(k != 15));
      end
      chk("R5 tx drop", tx_avail, 0);
    end

    // R11 time-out
    ctl(8'hC9);
    tmo();
    chk("R11 timeout empty", rxreq_n, 1);
    rp(8'h51); rp(8'h52);
    chk("R11 below level", rxreq_n, 1);
    tmo();
    chk("R11 timeout", rxreq_n, 0);
    hr();
    chk("R11 hold", rxreq_n, 0);
    hr();
    chk("R11 release", rxreq_n, 1);

    // R3 flushes
    for (int n = 0; n < 5; n++) rp(8'(n + 1));
    hw(8'h77); hw(8'h78);
    ctl(8'hCB);
    chk("R3 rx flushed", host_rdata, 0);
    chk("R3 rx req", rxreq_n, 1);
    chk("R3 tx kept", tx_avail, 1);
    chk("R3 bit clears", ctl_rdata, 8'hC9);
    ctl(8'hCD);
    chk("R3 tx flushed", tx_avail, 0);
    chk("R3 bit clears tx", ctl_rdata, 8'hC9);

    // R2 enable change empties both queues
    rp(8'h61); hw(8'h62);
    ctl(8'h00);
    chk("R2 toggle rx", rxreq_n, 1);
    chk("R2 toggle tx", tx_avail, 0);
    chk("R1 mode kept", ctl_rdata, 8'hC8);

    finish_run();
  end
endmodule